// File: doc/BRIEF.md
# Event-Driven Timer/Counter

This block is a timer/counter core driven by two incoming event lines. Each line has its own enable and an optional polarity inversion. Each line also has a 3-bit action code, and the two lines use different action tables. Between them the lines can start, stop or retrigger the counter, gate its stepping, steer its direction, nudge it one step up or down, capture period and pulse width into two capture channels, or latch a non-recoverable fault.

The counter runs between zero and a programmable top value. It produces single-cycle output events for a wrap past top or zero, for a retrigger, and for a counter-cycle position chosen by a 2-bit selector. Each of four compare/capture channels can also produce a match or capture event. A single configuration word, written through a write strobe, holds every enable, inversion, action code and selector.

Each event input is a synchronous signal. Edge-type actions fire on every cycle in which the effective (enabled, possibly inverted) input is high. Level-type actions follow the effective level in every cycle. All event outputs, and the count, are registered, so they show the result of a cause one clock edge after that cause. A configuration write takes effect from the edge after the write strobe.

Top module: `evt_timer`

## Requirements
- R1: After reset the count is 0, the counter is stopped, the fault flag is clear, every event output is 0 and every capture value is 0. The configuration word is all zero, and its bit fields are: action0 [2:0], action1 [5:3], cycle selector [7:6], enable0 [8], enable1 [9], invert0 [10], invert1 [11], wrap-event enable [12], retrigger-event enable [13], cycle-event enable [14], channel output-event enables [18:15] (channel i at bit 15+i) and channel input-event enables [22:19] (channel i at bit 19+i).
- R2: The effective input is the raw input XOR its invert bit, AND its enable bit. An input whose enable is 0 has no effect on the counter or on any output.
- R3: While running and not gated, the counter steps once per clock. Counting up from top goes to 0, and counting down from 0 goes to top. Each such wrap pulses the wrap event when its enable is set.
- R4: Action code 1, on either input, is a retrigger. It sets the counter running and loads 0 (counting up) or top (counting down). It pulses the retrigger event when its enable is set.
- R5: Input0 code 2 allows one step per cycle in which the input is high. Code 5 does the same while the level is held high. With either code and the input low, a running counter holds its value.
- R6: Input0 code 3 starts a stopped counter without changing the count, and the count steps from the next edge. Input1 code 3 stops the counter, and the count then holds.
- R7: Input0 code 4 steps the count up by one and input1 code 4 steps it down by one, even while the counter is stopped. When both fire in the same cycle the count does not change.
- R8: Input1 code 2 makes the counter count down while the effective level is high and up while it is low.
- R9: Input1 codes 5 and 6 capture on the effective input's edges. A rising edge copies the count into the period channel and restarts the counter from 0. A falling edge copies the count into the pulse-width channel. Code 5 uses channel 0 for the period and channel 1 for the pulse width; code 6 swaps the two. A capture happens only if the target channel's input-event enable is set.
- R10: Code 7 on either input sets a sticky fault flag and stops the counter. While the flag is set, no action changes the count or restarts the counter. Only reset clears the flag.
- R11: With the cycle-event enable set, the selector picks when the cycle event fires. 0: on a wrap, and when a retrigger or start begins a cycle. 1: on a wrap, and on a stop while running. 2: on a wrap only. 3: on a start or retrigger from the stopped state, and on a stop while running, but not on a wrap.
- R12: A channel whose input-event enable is 0 compares. It signals a match when a counter step lands on its compare value. A channel whose input-event enable is 1 captures the count on its capture request, and ignores the request when that enable is 0. A match or capture pulses the channel's output event only if the channel's output-event enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 15+2*N_CH | Configuration word |
| evt0_in | input | 1 | Event input 0 |
| evt1_in | input | 1 | Event input 1 |
| period_top | input | CNT_W | Counter top value |
| cmp_val | input | N_CH*CNT_W | Compare values, channel i at bits i*CNT_W |
| cap_req | input | N_CH | Per-channel capture request pulses |
| count | output | CNT_W | Current count |
| running | output | 1 | Counter is running |
| fault | output | 1 | Sticky fault flag |
| ovf_evt | output | 1 | Wrap (overflow/underflow) event |
| rtg_evt | output | 1 | Retrigger event |
| cyc_evt | output | 1 | Counter-cycle event |
| mc_evt | output | N_CH | Per-channel match/capture events |
| cap_val | output | N_CH*CNT_W | Captured values, channel i at bits i*CNT_W |

## Verification
The assertions assume that period_top is not lowered below the current count while the counter runs. This keeps the count no greater than top, so a wrap always lands on zero or on the top value seen one cycle earlier. The stimulus respects this. It changes the top value only in the same cycle as a retrigger, or when the count is already below the new top. It also drives the event lines and capture requests only between clock edges, as clean synchronous levels.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [2:0] {
    A0_NONE  = 3'd0,
    A0_RTG   = 3'd1,
    A0_EVCNT = 3'd2,
    A0_START = 3'd3,
    A0_INC   = 3'd4,
    A0_LVCNT = 3'd5,
    A0_RSVD  = 3'd6,
    A0_FAULT = 3'd7
  } act0_e;

  typedef enum logic [2:0] {
    A1_NONE  = 3'd0,
    A1_RTG   = 3'd1,
    A1_DIR   = 3'd2,
    A1_STOP  = 3'd3,
    A1_DEC   = 3'd4,
    A1_PPW   = 3'd5,
    A1_PWP   = 3'd6,
    A1_FAULT = 3'd7
  } act1_e;

  typedef enum logic [1:0] {
    CY_BEGIN = 2'd0,
    CY_END   = 2'd1,
    CY_WRAP  = 2'd2,
    CY_EDGES = 2'd3
  } cyc_sel_e;

  // Non-channel part of the configuration word, LSB is action0 bit 0.
  typedef struct packed {
    logic     cyc_oe;
    logic     rtg_oe;
    logic     ovf_oe;
    logic     inv1;
    logic     inv0;
    logic     en1;
    logic     en0;
    cyc_sel_e cyc_sel;
    act1_e    act1;
    act0_e    act0;
  } cfg_t;

  localparam int CFG_BASE_W = $bits(cfg_t);

endpackage

// File: rtl/evt_timer_cfg.sv
module evt_timer_cfg
  import evt_timer_pkg::*;
#(
  parameter int N_CH  = 4,
  localparam int CFG_W = CFG_BASE_W + 2 * N_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output cfg_t              cfg,
  output logic [N_CH-1:0]   cc_oe,
  output logic [N_CH-1:0]   cc_ie
);

  cfg_t            cfg_q, cfg_n;
  logic [N_CH-1:0] oe_q, oe_n, ie_q, ie_n;

  always_comb begin
    cfg_n = cfg_q;
    oe_n  = oe_q;
    ie_n  = ie_q;
    if (we) begin
      cfg_n = cfg_t'(wdata[CFG_BASE_W-1:0]);
      oe_n  = wdata[CFG_BASE_W +: N_CH];
      ie_n  = wdata[CFG_BASE_W + N_CH +: N_CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      oe_q  <= '0;
      ie_q  <= '0;
    end else begin
      cfg_q <= cfg_n;
      oe_q  <= oe_n;
      ie_q  <= ie_n;
    end
  end

  assign cfg   = cfg_q;
  assign cc_oe = oe_q;
  assign cc_ie = ie_q;

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             evt0,
  input  logic             evt1,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt_cur,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step,
  output logic             per_cap,
  output logic             pw_cap,
  output logic             per_to_ch1,
  output logic             running,
  output logic             fault,
  output logic             ovf_evt,
  output logic             rtg_evt,
  output logic             cyc_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic run_q, run_n, flt_q, flt_n, e1_q;
  logic ovf_q, ovf_n, rtg_q, rtg_n, cyc_q, cyc_n;

  logic e0, e1;
  logic fault_hit, stop_hit, rtg_hit, start_hit, inc_hit, dec_hit;
  logic ppw_mode, e1_rise, e1_fall, down_lvl, gated, do_step, go_down;
  logic beg_c, end_c, bnd_c, wrap_c, rtg_c;

  // Effective inputs: inversion then enable.
  assign e0 = cfg.en0 & (evt0 ^ cfg.inv0);
  assign e1 = cfg.en1 & (evt1 ^ cfg.inv1);

  assign fault_hit = (e0 && cfg.act0 == A0_FAULT) || (e1 && cfg.act1 == A1_FAULT);
  assign stop_hit  = e1 && cfg.act1 == A1_STOP;
  assign rtg_hit   = (e0 && cfg.act0 == A0_RTG) || (e1 && cfg.act1 == A1_RTG);
  assign start_hit = e0 && cfg.act0 == A0_START;
  assign inc_hit   = e0 && cfg.act0 == A0_INC;
  assign dec_hit   = e1 && cfg.act1 == A1_DEC;
  assign ppw_mode  = (cfg.act1 == A1_PPW) || (cfg.act1 == A1_PWP);
  assign e1_rise   = ppw_mode && e1 && !e1_q;
  assign e1_fall   = ppw_mode && !e1 && e1_q;
  assign down_lvl  = (cfg.act1 == A1_DIR) && e1;
  assign gated     = (cfg.act0 == A0_EVCNT) || (cfg.act0 == A0_LVCNT);
  assign do_step   = (inc_hit != dec_hit) ||
                     (!inc_hit && !dec_hit && run_q && (!gated || e0));
  assign go_down   = dec_hit ? 1'b1 : (inc_hit ? 1'b0 : down_lvl);

  always_comb begin
    cnt_n   = cnt_q;
    run_n   = run_q;
    flt_n   = flt_q;
    beg_c   = 1'b0;
    end_c   = 1'b0;
    bnd_c   = 1'b0;
    wrap_c  = 1'b0;
    rtg_c   = 1'b0;
    step    = 1'b0;
    per_cap = 1'b0;
    pw_cap  = 1'b0;
    if (!flt_q) begin
      if (fault_hit) begin
        flt_n = 1'b1;
        run_n = 1'b0;
      end else if (stop_hit) begin
        run_n = 1'b0;
        end_c = run_q;
      end else if (rtg_hit) begin
        run_n = 1'b1;
        cnt_n = down_lvl ? top : '0;
        rtg_c = 1'b1;
        beg_c = 1'b1;
        bnd_c = !run_q;
      end else if (e1_rise) begin
        per_cap = 1'b1;
        run_n   = 1'b1;
        cnt_n   = '0;
        beg_c   = 1'b1;
        bnd_c   = !run_q;
      end else begin
        pw_cap = e1_fall;
        if (start_hit && !run_q) begin
          run_n = 1'b1;
          beg_c = 1'b1;
          bnd_c = 1'b1;
        end
        if (do_step) begin
          step = 1'b1;
          if (go_down) begin
            if (cnt_q == '0) begin
              cnt_n  = top;
              wrap_c = 1'b1;
            end else begin
              cnt_n = cnt_q - ONE;
            end
          end else begin
            if (cnt_q == top) begin
              cnt_n  = '0;
              wrap_c = 1'b1;
            end else begin
              cnt_n = cnt_q + ONE;
            end
          end
        end
      end
    end
    ovf_n = cfg.ovf_oe & wrap_c;
    rtg_n = cfg.rtg_oe & rtg_c;
    unique case (cfg.cyc_sel)
      CY_BEGIN: cyc_n = cfg.cyc_oe & (beg_c | wrap_c);
      CY_END:   cyc_n = cfg.cyc_oe & (end_c | wrap_c);
      CY_WRAP:  cyc_n = cfg.cyc_oe & wrap_c;
      default:  cyc_n = cfg.cyc_oe & (bnd_c | end_c);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      flt_q <= 1'b0;
      e1_q  <= 1'b0;
      ovf_q <= 1'b0;
      rtg_q <= 1'b0;
      cyc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      run_q <= run_n;
      flt_q <= flt_n;
      e1_q  <= e1;
      ovf_q <= ovf_n;
      rtg_q <= rtg_n;
      cyc_q <= cyc_n;
    end
  end

  assign cnt_cur    = cnt_q;
  assign cnt_nxt    = cnt_n;
  assign per_to_ch1 = (cfg.act1 == A1_PWP);
  assign running    = run_q;
  assign fault      = flt_q;
  assign ovf_evt    = ovf_q;
  assign rtg_evt    = rtg_q;
  assign cyc_evt    = cyc_q;

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan #(
  parameter int CNT_W = 8,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe,
  input  logic             ie,
  input  logic             req,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt_cur,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             step,
  input  logic             per_cap,
  input  logic             pw_cap,
  input  logic             per_to_ch1,
  output logic [CNT_W-1:0] cap_val,
  output logic             mc_evt
);

  logic [CNT_W-1:0] cap_q, cap_n;
  logic             mc_q, mc_n;
  logic             ppw_hit, cap_hit, match;

  generate
    if (IDX == 0) begin : g_ch0
      assign ppw_hit = (per_cap && !per_to_ch1) || (pw_cap && per_to_ch1);
    end else if (IDX == 1) begin : g_ch1
      assign ppw_hit = (per_cap && per_to_ch1) || (pw_cap && !per_to_ch1);
    end else begin : g_chn
      assign ppw_hit = 1'b0;
    end
  endgenerate

  assign cap_hit = ie && (req || ppw_hit);
  assign match   = !ie && step && (cnt_nxt == cmp);

  always_comb begin
    cap_n = cap_q;
    if (cap_hit) cap_n = cnt_cur;
    mc_n = oe && (cap_hit || match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      mc_q  <= 1'b0;
    end else begin
      cap_q <= cap_n;
      mc_q  <= mc_n;
    end
  end

  assign cap_val = cap_q;
  assign mc_evt  = mc_q;

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4,
  localparam int CFG_W = CFG_BASE_W + 2 * N_CH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic                    evt0_in,
  input  logic                    evt1_in,
  input  logic [CNT_W-1:0]        period_top,
  input  logic [N_CH*CNT_W-1:0]   cmp_val,
  input  logic [N_CH-1:0]         cap_req,
  output logic [CNT_W-1:0]        count,
  output logic                    running,
  output logic                    fault,
  output logic                    ovf_evt,
  output logic                    rtg_evt,
  output logic                    cyc_evt,
  output logic [N_CH-1:0]         mc_evt,
  output logic [N_CH*CNT_W-1:0]   cap_val
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cfg_t            cfg;
  logic [N_CH-1:0] cc_oe_q, cc_ie_q;
  logic [CNT_W-1:0] cnt_cur, cnt_nxt;
  logic step, per_cap, pw_cap, per_to_ch1;

  evt_timer_cfg #(.N_CH(N_CH)) u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .cc_oe (cc_oe_q),
    .cc_ie (cc_ie_q)
  );

  evt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg        (cfg),
    .evt0       (evt0_in),
    .evt1       (evt1_in),
    .top        (period_top),
    .cnt_cur    (cnt_cur),
    .cnt_nxt    (cnt_nxt),
    .step       (step),
    .per_cap    (per_cap),
    .pw_cap     (pw_cap),
    .per_to_ch1 (per_to_ch1),
    .running    (running),
    .fault      (fault),
    .ovf_evt    (ovf_evt),
    .rtg_evt    (rtg_evt),
    .cyc_evt    (cyc_evt)
  );

  assign count = cnt_cur;

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    evt_timer_chan #(.CNT_W(CNT_W), .IDX(i)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .oe         (cc_oe_q[i]),
      .ie         (cc_ie_q[i]),
      .req        (cap_req[i]),
      .cmp        (cmp_val[i*CNT_W +: CNT_W]),
      .cnt_cur    (cnt_cur),
      .cnt_nxt    (cnt_nxt),
      .step       (step),
      .per_cap    (per_cap),
      .pw_cap     (pw_cap),
      .per_to_ch1 (per_to_ch1),
      .cap_val    (cap_val[i*CNT_W +: CNT_W]),
      .mc_evt     (mc_evt[i])
    );
  end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period_top,
  input logic             running,
  input logic             fault,
  input logic             ovf_evt,
  input logic             rtg_evt,
  input logic [N_CH-1:0]  mc_evt,
  input logic [N_CH-1:0]  cc_oe
);

  // R10: fault flag never drops once set
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R10: a faulted counter keeps its value and stays stopped
  p_fault_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ($stable(count) && !running));

  // R4: a retrigger event always leaves the counter running
  p_rtg_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rtg_evt |-> running);

  // R3: a wrap event lands on zero or on the top value
  p_wrap_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (count == '0 || count == $past(period_top)));

  // R12: no channel event without its output enable
  p_mc_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_evt & ~$past(cc_oe)) == '0);

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .count      (count),
  .period_top (period_top),
  .running    (running),
  .fault      (fault),
  .ovf_evt    (ovf_evt),
  .rtg_evt    (rtg_evt),
  .mc_evt     (mc_evt),
  .cc_oe      (cc_oe_q)
);

// File: tb/test_evt_timer.sv
module test_evt_timer;

  localparam int CNT_W = 8;
  localparam int N_CH  = 4;
  localparam int CFG_W = 15 + 2 * N_CH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic evt0_in = 1'b0, evt1_in = 1'b0;
  logic [CNT_W-1:0] period_top = 8'd9;
  logic [N_CH*CNT_W-1:0] cmp_val = '0;
  logic [N_CH-1:0] cap_req = '0;
  logic [CNT_W-1:0] count;
  logic running, fault, ovf_evt, rtg_evt, cyc_evt;
  logic [N_CH-1:0] mc_evt;
  logic [N_CH*CNT_W-1:0] cap_val;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  evt_timer #(.CNT_W(CNT_W), .N_CH(N_CH)) i_evt_timer (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .evt0_in, .evt1_in, .period_top,
    .cmp_val, .cap_req, .count, .running, .fault, .ovf_evt, .rtg_evt,
    .cyc_evt, .mc_evt, .cap_val
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wcfg(input logic [CFG_W-1:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) evt0_in = 1'b1; else evt1_in = 1'b1;
    tick();
    evt0_in = 1'b0;
    evt1_in = 1'b0;
  endtask

  function automatic logic [CFG_W-1:0] mk(
    input logic [2:0] a0, input logic [2:0] a1, input logic [1:0] sel,
    input logic en0, input logic en1, input logic inv0, input logic inv1,
    input logic ovf, input logic rtg, input logic cyc,
    input logic [3:0] oe, input logic [3:0] ie);
    return {ie, oe, cyc, rtg, ovf, inv1, inv0, en1, en0, sel, a1, a0};
  endfunction

  function automatic int capv(input int ch);
    return int'(cap_val[ch*CNT_W +: CNT_W]);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    int c1;
    bit ew, es, eb;
    #12 rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 fault", fault, 0);
    chk("R1 events", {ovf_evt, rtg_evt, cyc_evt, mc_evt}, 0);
    chk("R1 capture", (cap_val == '0), 1);
    // R2: disabled inputs ignored after reset
    pulse(0);
    pulse(1);
    chk("R2 disabled count", count, 0);
    chk("R2 disabled running", running, 0);

    // R3/R4: free-run sweep over several top values
    wcfg(mk(3'd1, 3'd0, 2'd0, 1, 0, 0, 0, 1, 0, 0, 4'h0, 4'h0));
    for (int p = 1; p <= 6; p++) begin
      period_top = CNT_W'(p);
      pulse(0);
      chk("R4 retrigger load", count, 0);
      chk("R4 running", running, 1);
      for (int k = 1; k <= 2 * p + 2; k++) begin
        tick();
        chk("R3 count", count, k % (p + 1));
        chk("R3 wrap event", ovf_evt, (k % (p + 1) == 0));
      end
    end

    // R8/R2/R4: direction by inverted level, down wrap
    period_top = 8'd5;
    wcfg(mk(3'd1, 3'd2, 2'd0, 1, 1, 0, 1, 1, 1, 0, 4'h0, 4'h0));
    pulse(0);
    chk("R4 down load top", count, 5);
    chk("R4 retrigger event", rtg_evt, 1);
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R8 down count", count, (k == 6) ? 5 : 5 - k);
      chk("R8 down wrap event", ovf_evt, (k == 6));
    end
    evt1_in = 1'b1;
    tick();
    evt1_in = 1'b0;
    chk("R2 invert gives up-count", count, 0);
    wcfg(mk(3'd1, 3'd2, 2'd0, 0, 1, 0, 1, 1, 1, 0, 4'h0, 4'h0));
    c = count;
    pulse(0);
    chk("R2 disabled input0", count, (c == 0) ? 5 : c - 1);
    chk("R2 disabled no retrigger event", rtg_evt, 0);

    // R6: stop and start
    period_top = 8'd9;
    wcfg(mk(3'd3, 3'd3, 2'd0, 1, 1, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    pulse(1);
    chk("R6 stopped", running, 0);
    c = count;
    repeat (3) tick();
    chk("R6 held while stopped", count, c);
    pulse(0);
    chk("R6 started", running, 1);
    chk("R6 start keeps count", count, c);
    tick();
    chk("R6 steps after start", count, (c == 9) ? 0 : c + 1);

    // R7: single steps while stopped
    pulse(1);
    wcfg(mk(3'd4, 3'd4, 2'd0, 1, 1, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    c = count;
    pulse(0);
    chk("R7 increment", count, c + 1);
    pulse(1);
    chk("R7 decrement", count, c);
    evt0_in = 1'b1;
    evt1_in = 1'b1;
    tick();
    evt0_in = 1'b0;
    evt1_in = 1'b0;
    chk("R7 both cancel", count, c);
    chk("R7 still stopped", running, 0);

    // R5: gated counting
    wcfg(mk(3'd2, 3'd1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    pulse(1);
    chk("R4 retrigger via input1", count, 0);
    repeat (3) tick();
    chk("R5 no event no step", count, 0);
    repeat (3) begin
      pulse(0);
      tick();
    end
    chk("R5 step per event", count, 3);
    wcfg(mk(3'd5, 3'd1, 2'd0, 1, 1, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    chk("R5 level low holds", count, 3);
    evt0_in = 1'b1;
    repeat (4) tick();
    evt0_in = 1'b0;
    chk("R5 level count", count, 7);
    tick();
    chk("R5 level released", count, 7);

    // R9: period and pulse width capture
    wcfg(mk(3'd0, 3'd5, 2'd0, 0, 1, 0, 0, 0, 0, 0, 4'h0, 4'h3));
    c = count;
    evt1_in = 1'b1;
    tick();
    chk("R9 restart on rise", count, 0);
    chk("R9 period in ch0", capv(0), c);
    repeat (3) tick();
    evt1_in = 1'b0;
    tick();
    chk("R9 width in ch1", capv(1), 3);
    chk("R9 count continues", count, 4);
    wcfg(mk(3'd0, 3'd6, 2'd0, 0, 1, 0, 0, 0, 0, 0, 4'h0, 4'h3));
    c = count;
    evt1_in = 1'b1;
    tick();
    chk("R9 swapped period in ch1", capv(1), c);
    repeat (2) tick();
    evt1_in = 1'b0;
    tick();
    chk("R9 swapped width in ch0", capv(0), 2);

    // R12: compare and capture channels
    cmp_val = '0;
    cmp_val[0*CNT_W +: CNT_W] = 8'd4;
    cmp_val[2*CNT_W +: CNT_W] = 8'd4;
    wcfg(mk(3'd1, 3'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'b1100, 4'b1000));
    pulse(0);
    for (int k = 1; k <= 9; k++) begin
      tick();
      chk("R12 count", count, k);
      chk("R12 match ch2", mc_evt[2], (k == 4));
      chk("R12 ch0 output disabled", mc_evt[0], 0);
    end
    c = count;
    c1 = capv(1);
    cap_req = 4'b1010;
    tick();
    cap_req = '0;
    chk("R12 capture ch3", capv(3), c);
    chk("R12 capture event ch3", mc_evt[3], 1);
    chk("R12 ch1 request ignored", capv(1), c1);

    // R11: cycle event selector sweep
    period_top = 8'd2;
    for (int s = 0; s < 4; s++) begin
      es = (s == 0) || (s == 3);
      ew = (s != 3);
      eb = (s == 1) || (s == 3);
      wcfg(mk(3'd1, 3'd3, 2'(s), 1, 1, 0, 0, 0, 0, 1, 4'h0, 4'h0));
      pulse(1);
      tick();
      pulse(0);
      chk("R11 begin from stopped", cyc_evt, es);
      for (int k = 1; k <= 3; k++) begin
        tick();
        chk("R11 count", count, k % 3);
        chk("R11 wrap", cyc_evt, (k == 3) ? ew : 0);
      end
      pulse(1);
      chk("R11 stop while running", cyc_evt, eb);
    end

    // R10: sticky fault
    period_top = 8'd9;
    wcfg(mk(3'd1, 3'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    pulse(0);
    wcfg(mk(3'd7, 3'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    pulse(0);
    chk("R10 fault set", fault, 1);
    chk("R10 stopped", running, 0);
    c = count;
    wcfg(mk(3'd1, 3'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'h0, 4'h0));
    pulse(0);
    tick();
    chk("R10 retrigger blocked", running, 0);
    chk("R10 count frozen", count, c);
    chk("R10 still faulted", fault, 1);

    finish_run();
  end

endmodule